// File: doc/BRIEF.md
# Sine Reference Generator

This block turns a low-frequency crystal clock into a digital sine reference for a ringing-signal converter. A two-bit rate select picks one of three whole-number clock-per-cycle ratios (1600, 1280 or 640 clocks per sine period). With a 32 kHz clock these ratios give 20 Hz, 25 Hz and 50 Hz. A different crystal scales all three frequencies by the same factor; for example, a 32.768 kHz clock on the slowest setting gives about 20.48 Hz. The fourth select code stops internal generation and passes an externally supplied sample through unchanged. That external sample has to use the same mid-scale offset as the internal one.

The samples are 10-bit offset binary and centred on mid-scale (512), not on zero. A period counter feeds a fractional residue that maps each clock of the period onto a 256-step phase index. A 65-entry quarter-wave table, computed when the design is elaborated and folded by symmetry, turns the phase index into an amplitude. A change of rate takes effect only when the current period ends, so the output never shows a cut-off cycle. Two one-clock strobes mark the crossings of mid-scale, one for rising crossings and one for falling crossings, so that a downstream relay can switch at the zero-volt point.

Top module: `sine_ref_gen`

## Requirements
- R1: While reset is asserted, and until the first clock after its release, `sample_out` is 512 and `sample_valid`, `zc_rise` and `zc_fall` are 0.
- R2: `rate_sel` codes 2'b00, 2'b01 and 2'b10 give an output period of exactly 1600, 1280 and 640 clocks respectively.
- R3: In clock t of a period (t = 0..N-1), the phase index is p = floor(t*256/N). One clock later, `sample_out` shows 512 + f(p) for p < 128 and 512 - f(p-128) otherwise, where f(u) = floor((2*num + den) / (2*den)), num = 511*16*u*(128-u), and den = 81920 - 4*u*(128-u).
- R4: The generated wave reaches exactly 1023 at phase 64 and exactly 1 at phase 192, and is 512 at phases 0 and 128. It never reaches 0.
- R5: A change of `rate_sel` made during a period is ignored until that period's last clock ends. The period that is running keeps its original length.
- R6: With code 2'b11 in effect, `sample_out` equals the `ext_sample` value captured at the previous clock edge, and `sample_valid` is 0.
- R7: While code 2'b11 is in effect, `rate_sel` is re-read on every clock. A generated code then starts a new period at phase 0 on the next clock, and `sample_valid` rises together with a `sample_out` of 512.
- R8: `zc_rise` is 1 for one clock when `sample_out` goes from below 512 to 512 or above. `zc_fall` is 1 for one clock on the opposite move. Both strobes work in pass-through as well as in generation.
- R9: `sample_valid` is 1 exactly when `sample_out` comes from the internal generator.
- R10: The first clock after reset release captures `rate_sel` and starts a period at phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | 00: 1600 clk/cycle, 01: 1280, 10: 640, 11: external pass-through |
| ext_sample | input | 10 | External offset-binary sample used in pass-through |
| sample_out | output | 10 | Offset-binary sine sample, mid-scale 512 |
| sample_valid | output | 1 | High while the output is internally generated |
| zc_rise | output | 1 | One-clock strobe on an upward mid-scale crossing |
| zc_fall | output | 1 | One-clock strobe on a downward mid-scale crossing |

## Verification
The bench changes the rate in the middle of a period. A design that switched at once would shorten that period instead of finishing it at 1600 clocks. It checks the exact peak (1023) and trough (1). A wrong fold in the quarter table would show up as a doubled or missing peak sample, or as a trough at 0. In pass-through it drives external values that cross, land exactly on, and stay at mid-scale. This shows whether the strobes fire on the boundary value and whether they last only one clock. The bench also leaves pass-through and applies reset in the middle of a period. A design that restarted anywhere but phase 0, or kept the old rate, would fail the per-clock model comparison right away.

// File: rtl/sine_ref_pkg.sv
package sine_ref_pkg;

  localparam logic [1:0] RATE_A   = 2'b00;
  localparam logic [1:0] RATE_B   = 2'b01;
  localparam logic [1:0] RATE_C   = 2'b10;
  localparam logic [1:0] RATE_EXT = 2'b11;

  // Rational sine approximation over a half period of `half` steps,
  // scaled to `amp` and rounded to nearest.
  function automatic longint quarter_amp(longint u, longint half, longint amp);
    longint p;
    longint num;
    longint den;
    p   = u * (half - u);
    num = amp * 64'sd16 * p;
    den = 64'sd5 * half * half - 64'sd4 * p;
    return (64'sd2 * num + den) / (64'sd2 * den);
  endfunction

endpackage

// File: rtl/sine_period_seq.sv
module sine_period_seq
  import sine_ref_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int PHASE_W = 8,
  parameter int DIV_A   = 1600,
  parameter int DIV_B   = 1280,
  parameter int DIV_C   = 640
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         sel_i,
  output logic               run_o,
  output logic               bypass_o,
  output logic [PHASE_W-1:0] phase_o
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] STEP = SUM_W'(1 << PHASE_W);

  logic               run_q, run_d;
  logic [1:0]         sel_q, sel_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   res_q, res_d;
  logic [PHASE_W-1:0] phase_q, phase_d;

  logic [SUM_W-1:0]   span;
  logic [SUM_W-1:0]   res_sum;
  logic               bypass;
  logic               wrap;
  logic               adv;

  always_comb begin
    case (sel_q)
      RATE_A:  span = SUM_W'(DIV_A);
      RATE_B:  span = SUM_W'(DIV_B);
      default: span = SUM_W'(DIV_C);
    endcase
  end

  assign bypass  = (sel_q == RATE_EXT);
  assign wrap    = ({1'b0, cnt_q} == (span - SUM_W'(1)));
  assign res_sum = {1'b0, res_q} + STEP;
  assign adv     = (res_sum >= span);

  always_comb begin
    run_d   = 1'b1;
    sel_d   = sel_q;
    cnt_d   = cnt_q + CNT_W'(1);
    res_d   = adv ? CNT_W'(res_sum - span) : CNT_W'(res_sum);
    phase_d = adv ? phase_q + PHASE_W'(1) : phase_q;
    if (!run_q || bypass || wrap) begin
      sel_d   = sel_i;
      cnt_d   = '0;
      res_d   = '0;
      phase_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sel_q   <= RATE_A;
      cnt_q   <= '0;
      res_q   <= '0;
      phase_q <= '0;
    end else begin
      run_q   <= run_d;
      sel_q   <= sel_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
      phase_q <= phase_d;
    end
  end

  assign run_o    = run_q;
  assign bypass_o = bypass;
  assign phase_o  = phase_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bypass) |-> ({1'b0, cnt_q} < span)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bypass && !wrap) |=> $stable(sel_q)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bypass && wrap) |=> (cnt_q == '0 && phase_q == '0)); // R2
  AST_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bypass && wrap) |-> (phase_q == '1)); // R3

endmodule

// File: rtl/sine_quarter_rom.sv
module sine_quarter_rom
  import sine_ref_pkg::*;
#(
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic [PHASE_W-1:0]  phase_i,
  output logic [SAMPLE_W-1:0] sample_o
);

  localparam int QW   = PHASE_W - 2;
  localparam int QN   = 1 << QW;
  localparam int HALF = 1 << (PHASE_W - 1);
  localparam int AMP  = (1 << (SAMPLE_W - 1)) - 1;
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic [SAMPLE_W-2:0] qtab [0:QN];

  for (genvar g = 0; g <= QN; g++) begin : g_tab
    assign qtab[g] = (SAMPLE_W-1)'(quarter_amp(longint'(g), longint'(HALF), longint'(AMP)));
  end

  logic [1:0]      quad;
  logic [QW-1:0]   idx;
  logic [QW:0]     addr;
  logic [SAMPLE_W-2:0] mag;

  assign quad = phase_i[PHASE_W-1 -: 2];
  assign idx  = phase_i[QW-1:0];

  always_comb begin
    if (quad[0]) addr = (QW+1)'(QN) - {1'b0, idx};
    else         addr = {1'b0, idx};
    mag = qtab[addr];
    if (quad[1]) sample_o = MID - {1'b0, mag};
    else         sample_o = MID + {1'b0, mag};
  end

endmodule

// File: rtl/sine_out_stage.sv
module sine_out_stage #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                bypass_i,
  input  logic [SAMPLE_W-1:0] gen_i,
  input  logic [SAMPLE_W-1:0] ext_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                zc_rise_o,
  output logic                zc_fall_o
);

  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic                valid_q, valid_d;
  logic                rise_q, rise_d;
  logic                fall_q, fall_d;

  always_comb begin
    if (!run_i)        sample_d = MID;
    else if (bypass_i) sample_d = ext_i;
    else               sample_d = gen_i;
    valid_d = run_i && !bypass_i;
    // At or above mid-scale is exactly the top bit of an offset-binary code.
    rise_d  =  sample_d[SAMPLE_W-1] && !sample_q[SAMPLE_W-1];
    fall_d  = !sample_d[SAMPLE_W-1] &&  sample_q[SAMPLE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= MID;
      valid_q  <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      sample_q <= sample_d;
      valid_q  <= valid_d;
      rise_q   <= rise_d;
      fall_q   <= fall_d;
    end
  end

  assign sample_o  = sample_q;
  assign valid_o   = valid_q;
  assign zc_rise_o = rise_q;
  assign zc_fall_o = fall_q;

  AST_ZC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q)); // R8
  AST_ZC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q); // R8
  AST_RESTART_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> (sample_q == MID)); // R7

endmodule

// File: rtl/sine_ref_gen.sv
module sine_ref_gen #(
  parameter int SAMPLE_W = 10,
  parameter int PHASE_W  = 8,
  parameter int DIV_A    = 1600,
  parameter int DIV_B    = 1280,
  parameter int DIV_C    = 640
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          rate_sel,
  input  logic [SAMPLE_W-1:0] ext_sample,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_valid,
  output logic                zc_rise,
  output logic                zc_fall
);

  localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                           : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int CNT_W   = $clog2(DIV_MAX);

  logic               run;
  logic               bypass;
  logic [PHASE_W-1:0] phase;
  logic [SAMPLE_W-1:0] gen_sample;

  sine_period_seq #(
    .CNT_W  (CNT_W),
    .PHASE_W(PHASE_W),
    .DIV_A  (DIV_A),
    .DIV_B  (DIV_B),
    .DIV_C  (DIV_C)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (rate_sel),
    .run_o   (run),
    .bypass_o(bypass),
    .phase_o (phase)
  );

  sine_quarter_rom #(
    .PHASE_W (PHASE_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_rom (
    .phase_i (phase),
    .sample_o(gen_sample)
  );

  sine_out_stage #(
    .SAMPLE_W(SAMPLE_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .bypass_i (bypass),
    .gen_i    (gen_sample),
    .ext_i    (ext_sample),
    .sample_o (sample_out),
    .valid_o  (sample_valid),
    .zc_rise_o(zc_rise),
    .zc_fall_o(zc_fall)
  );

  AST_INT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (sample_out != '0)); // R4

endmodule

// File: tb/sine_ref_gen_tb.sv
module sine_ref_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [9:0] ext_sample = 10'd0;
  logic [9:0] sample_out;
  logic       sample_valid;
  logic       zc_rise;
  logic       zc_fall;

  always #4 clk = ~clk;

  sine_ref_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .ext_sample  (ext_sample),
    .sample_out  (sample_out),
    .sample_valid(sample_valid),
    .zc_rise     (zc_rise),
    .zc_fall     (zc_fall)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference model
  bit m_run;
  int m_sel;
  int m_t;
  int e_sample = 512;
  bit e_valid, e_zr, e_zf;
  bit armed = 1'b0;

  function automatic int period_of(int s);
    if (s == 0) return 1600;
    if (s == 1) return 1280;
    return 640;
  endfunction

  function automatic int ref_amp(int a);
    int u;
    longint p, num, den, f;
    u   = (a < 128) ? a : a - 128;
    p   = longint'(u) * longint'(128 - u);
    num = 64'sd511 * 64'sd16 * p;
    den = 64'sd81920 - 64'sd4 * p;
    f   = (64'sd2 * num + den) / (64'sd2 * den);
    return (a < 128) ? 512 + int'(f) : 512 - int'(f);
  endfunction

  always @(posedge clk) begin
    int ns;
    bit nv;
    cyc = cyc + 1;
    if (!rst_n) begin
      m_run = 0; m_sel = 0; m_t = 0;
      e_sample = 512; e_valid = 0; e_zr = 0; e_zf = 0;
      armed = 1'b1;
    end else begin
      if (!m_run)          ns = 512;
      else if (m_sel == 3) ns = int'(ext_sample);
      else                 ns = ref_amp((m_t * 256) / period_of(m_sel));
      nv   = m_run && (m_sel != 3);
      e_zr = (ns >= 512) && (e_sample < 512);
      e_zf = (ns < 512) && (e_sample >= 512);
      e_sample = ns;
      e_valid  = nv;
      if (!m_run) begin
        m_run = 1; m_sel = int'(rate_sel); m_t = 0;
      end else if (m_sel == 3 || m_t == period_of(m_sel) - 1) begin
        m_sel = int'(rate_sel); m_t = 0;
      end else begin
        m_t = m_t + 1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (int'(sample_out) != e_sample) begin
        errors++;
        $display("FAIL R3 cyc %0d sample_out act=%0d exp=%0d", cyc, sample_out, e_sample);
      end
      if (sample_valid != e_valid) begin
        errors++;
        $display("FAIL R9 cyc %0d sample_valid act=%0d exp=%0d", cyc, sample_valid, e_valid);
      end
      if (zc_rise != e_zr || zc_fall != e_zf) begin
        errors++;
        $display("FAIL R8 cyc %0d zc rise/fall act=%0d/%0d exp=%0d/%0d",
                 cyc, zc_rise, zc_fall, e_zr, e_zf);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(output int at);
    at = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (zc_rise) begin at = cyc; break; end
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int t0, t1, t2, mx, mn;
    repeat (3) @(negedge clk);
    check(sample_out == 10'd512 && !sample_valid && !zc_rise && !zc_fall,
          "R1 reset state", int'(sample_out), 512);
    rate_sel = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);
    check(!sample_valid && sample_out == 10'd512, "R1 first clock after release",
          int'(sample_valid), 0);
    @(negedge clk);
    check(sample_valid && sample_out == 10'd512, "R10 start at phase 0",
          int'(sample_out), 512);

    // R2 / R4 on the 1600-clock setting
    wait_rise(t0);
    mx = 0; mn = 1023;
    for (int i = 0; i < 1600; i++) begin
      @(negedge clk);
      if (int'(sample_out) > mx) mx = int'(sample_out);
      if (int'(sample_out) < mn) mn = int'(sample_out);
    end
    check(mx == 1023, "R4 peak", mx, 1023);
    check(mn == 1, "R4 trough", mn, 1);
    wait_rise(t1);
    check(t1 - t0 == 3200, "R2 two periods at code 00", t1 - t0, 3200);

    // R5: mid-period change to the 640-clock rate
    wait_rise(t0);
    repeat (300) @(negedge clk);
    rate_sel = 2'b10;
    wait_rise(t1);
    check(t1 - t0 == 1600, "R5 running period kept", t1 - t0, 1600);
    wait_rise(t2);
    check(t2 - t1 == 640, "R2 period at code 10", t2 - t1, 640);

    rate_sel = 2'b01;
    wait_rise(t0);
    wait_rise(t1);
    wait_rise(t2);
    check(t2 - t1 == 1280, "R2 period at code 01", t2 - t1, 1280);

    // R6 / R8: pass-through
    rate_sel = 2'b11;
    ext_sample = 10'd512;
    for (int i = 0; i < 2000 && sample_valid; i++) @(negedge clk);
    @(negedge clk);
    check(!sample_valid, "R6 valid low in pass-through", int'(sample_valid), 0);
    ext_sample = 10'd700;
    @(negedge clk);
    check(sample_out == 10'd700, "R6 follows ext", int'(sample_out), 700);
    ext_sample = 10'd300;
    @(negedge clk);
    check(sample_out == 10'd300 && zc_fall && !zc_rise, "R8 fall in pass-through",
          int'(zc_fall), 1);
    ext_sample = 10'd512;
    @(negedge clk);
    check(zc_rise && !zc_fall, "R8 rise on exact mid-scale", int'(zc_rise), 1);
    @(negedge clk);
    check(!zc_rise && !zc_fall, "R8 strobe is one clock", int'(zc_rise), 0);
    ext_sample = 10'd100;
    @(negedge clk);

    // R7: leave pass-through
    rate_sel = 2'b10;
    @(negedge clk);
    check(!sample_valid && sample_out == 10'd100, "R7 last pass-through sample",
          int'(sample_out), 100);
    @(negedge clk);
    check(sample_valid && sample_out == 10'd512 && zc_rise, "R7 restart at phase 0",
          int'(sample_out), 512);
    wait_rise(t0);
    check(t0 - cyc == 0 && t0 > 0, "R7 cycle running", t0, cyc);

    // reset in the middle of a period
    repeat (123) @(negedge clk);
    armed = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(sample_out == 10'd512 && !sample_valid, "R1 mid-run reset",
          int'(sample_out), 512);
    rate_sel = 2'b01;
    rst_n = 1'b1;
    wait_rise(t0);
    wait_rise(t1);
    check(t1 - t0 == 1280, "R10 rate captured after reset", t1 - t0, 1280);
    repeat (10) @(negedge clk);

    summary();
    $finish;
  end

endmodule